// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block runs hardware flow control for one UART channel without software help. It sits between the receive FIFO, the transmitter and the modem pins. From the receive FIFO fill count it decides whether the far end may keep sending, and drives the active-low RTS pin to match. From the active-low CTS pin it decides whether the local transmitter may begin its next character.

The RTS decision has hysteresis. A threshold register holds two 4-bit fields, and each field is scaled by four to give a character level from 0 to 60. When the fill count reaches the halt level, RTS goes high. It goes low again only after the FIFO has drained to the resume level. The threshold register accepts writes only while the enhanced-functions enable is set.

On the CTS side, the pin is synchronised and turned into a start permission. A character already being shifted out always completes, because the transmitter samples the permission only when it begins a new character. Edges on RTS and on CTS raise sticky interrupt flags, and a status read clears them.

Top module: `flowctl_top`

## Requirements
- R1: After reset, the threshold register reads 8'h0F (resume field bits [7:4] = 0, halt field bits [3:0] = 15). After reset, rts_n is 1, tx_start_ok is 1, and irq_rts, irq_cts and irq are all 0.
- R2: A write on cfg_we loads cfg_wdata into the threshold register at the next clock edge, but only when enh_en is 1. With enh_en at 0 the register keeps its value.
- R3: While auto_rts_en is 0, rts_n equals the inverse of sw_rts one clock after sw_rts is sampled.
- R4: While auto_rts_en is 1, a fill count at or above 4 × halt field drives rts_n to 1 one clock later.
- R5: While auto_rts_en is 1, a fill count below the halt level and at or below 4 × resume field drives rts_n to 0 one clock later.
- R6: While auto_rts_en is 1, a fill count strictly between the resume and halt levels leaves rts_n unchanged.
- R7: When the resume level is at or above the halt level, the halt comparison takes priority.
- R8: While auto_cts_en is 0, tx_start_ok is 1 whatever cts_n does.
- R9: While auto_cts_en is 1, tx_start_ok equals the inverse of cts_n delayed by two clocks of synchronisation.
- R10: While auto_rts_en and rts_irq_en are both 1, each change of rts_n sets irq_rts in the same clock that rts_n changes. With rts_irq_en at 0, no change of rts_n sets it.
- R11: While auto_cts_en is 1, each edge of the synchronised CTS sets irq_cts one clock after tx_start_ok changes.
- R12: A stat_rd pulse clears irq_rts and irq_cts at the next edge unless a new event arrives in that same clock. irq is the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Threshold register write strobe |
| cfg_wdata | input | 8 | Threshold write data, {resume[3:0], halt[3:0]} |
| enh_en | input | 1 | Enhanced-functions enable, gates threshold writes |
| auto_rts_en | input | 1 | Hardware drives RTS from the fill count |
| auto_cts_en | input | 1 | CTS gates transmitter starts |
| sw_rts | input | 1 | Software RTS request, 1 = assert |
| rts_irq_en | input | 1 | Enables the RTS-change flag |
| rx_fill | input | 7 | Receive FIFO fill count, 0 to 64 |
| cts_n | input | 1 | Clear-to-send pin, active low |
| stat_rd | input | 1 | Status read, clears the flags |
| thr_q | output | 8 | Threshold register contents |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_start_ok | output | 1 | Transmitter may begin a new character |
| irq_rts | output | 1 | Sticky RTS-change flag |
| irq_cts | output | 1 | Sticky CTS-change flag |
| irq | output | 1 | OR of the two flags |

## Verification
The hysteresis is walked with one sequence of fill counts that first rises through the halt level and then falls back through the gap. Within that sequence, counts one below each level are separated from counts exactly at it, and holding in the gap is separated from tracking. A second threshold setting with the resume level above the halt level shows which comparison wins. The CTS pin is toggled with and without auto-CTS, so the two-clock synchroniser delay is told apart from gating and from the flag timing. The RTS flag is tried with its enable off and on, so that a missing enable and a missing event can each be detected.

// File: rtl/flowctl_pkg.sv
// Shared sizing for the flow controller.
// Assumes a receive FIFO whose depth fits the fill count width derived here.
package flowctl_pkg;
    localparam int unsigned FIFO_DEPTH  = 64;
    localparam int unsigned FIELD_W     = 4;
    localparam int unsigned LVL_SHIFT   = 2;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned FILL_W      = $clog2(FIFO_DEPTH + 1);
    localparam logic [2*FIELD_W-1:0] THR_RESET = {{FIELD_W{1'b0}}, {FIELD_W{1'b1}}};
endpackage

// File: rtl/flowctl_thresh_reg.sv
// Threshold register: {resume, halt}, each FIELD_W bits wide.
// Assumes the write strobe is one clock wide. Writes are dropped while enh_en is low.
module flowctl_thresh_reg #(
    parameter int unsigned FIELD_W = 4,
    parameter logic [2*FIELD_W-1:0] RESET_VAL = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 enh_en,
    input  logic [2*FIELD_W-1:0] wdata,
    output logic [2*FIELD_W-1:0] q
);
    // Load on a gated write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)               q <= RESET_VAL;
        else if (wr_en && enh_en) q <= wdata;
    end
endmodule

// File: rtl/flowctl_rts_hyst.sv
// RTS driver with a hysteresis window between a halt level and a resume level.
// Assumes the levels are already scaled to characters. Halt wins on overlap.
// The state stays "halted" while auto mode is off, so turning auto mode on
// mid-window keeps the far end stopped until the FIFO drains.
module flowctl_rts_hyst #(
    parameter int unsigned FILL_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              sw_rts,
    input  logic [FILL_W-1:0] fill,
    input  logic [FILL_W-1:0] halt_lvl,
    input  logic [FILL_W-1:0] resume_lvl,
    output logic              rts_n,
    output logic              chg_evt
);
    logic halted;
    logic halted_nxt;
    logic rts_nxt;

    // Next hysteresis state: halt first, then resume, otherwise hold.
    always_comb begin
        if (fill >= halt_lvl)        halted_nxt = 1'b1;
        else if (fill <= resume_lvl) halted_nxt = 1'b0;
        else                         halted_nxt = halted;
        rts_nxt = auto_en ? halted_nxt : ~sw_rts;
    end

    // An RTS change under auto mode is a flag event.
    assign chg_evt = auto_en && (rts_nxt != rts_n);

    // Register the hysteresis state and the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b1;
            rts_n  <= 1'b1;
        end else begin
            halted <= auto_en ? halted_nxt : 1'b1;
            rts_n  <= rts_nxt;
        end
    end
endmodule

// File: rtl/flowctl_cts_gate.sv
// CTS synchroniser and transmit-start gate with edge detection.
// Assumes cts_n is asynchronous. The synchroniser resets to "not clear" (1).
// Only new character starts are gated, so a character in flight completes.
module flowctl_cts_gate #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_n,
    output logic tx_start_ok,
    output logic edge_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cts_s;

    assign cts_s = sync_q[SYNC_STAGES-1];

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n};
    end

    // Remember the last synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= cts_s;
    end

    assign tx_start_ok = ~auto_en | ~cts_s;
    assign edge_evt    = auto_en && (cts_s != prev_q);
endmodule

// File: rtl/flowctl_top.sv
// Automatic RTS/CTS flow controller for one UART channel.
// Assumes rx_fill comes from the receive FIFO in the same clock domain.
module flowctl_top
    import flowctl_pkg::*;
#(
    parameter int unsigned P_DEPTH   = FIFO_DEPTH,
    parameter int unsigned P_FIELD_W = FIELD_W,
    parameter int unsigned P_SHIFT   = LVL_SHIFT,
    parameter int unsigned P_SYNC    = SYNC_STAGES,
    localparam int unsigned P_FILL_W = $clog2(P_DEPTH + 1),
    localparam int unsigned P_PAD    = P_FILL_W - P_FIELD_W - P_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [2*P_FIELD_W-1:0] cfg_wdata,
    input  logic                   enh_en,
    input  logic                   auto_rts_en,
    input  logic                   auto_cts_en,
    input  logic                   sw_rts,
    input  logic                   rts_irq_en,
    input  logic [P_FILL_W-1:0]    rx_fill,
    input  logic                   cts_n,
    input  logic                   stat_rd,
    output logic [2*P_FIELD_W-1:0] thr_q,
    output logic                   rts_n,
    output logic                   tx_start_ok,
    output logic                   irq_rts,
    output logic                   irq_cts,
    output logic                   irq
);
    logic [P_FILL_W-1:0] halt_lvl;
    logic [P_FILL_W-1:0] resume_lvl;
    logic                rts_evt;
    logic                cts_evt;

    flowctl_thresh_reg #(.FIELD_W(P_FIELD_W), .RESET_VAL({{P_FIELD_W{1'b0}}, {P_FIELD_W{1'b1}}})) u_thr (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .enh_en(enh_en),
        .wdata(cfg_wdata), .q(thr_q)
    );

    // Scale each field to a character level.
    generate
        if (P_PAD > 0) begin : g_pad
            assign halt_lvl   = {{P_PAD{1'b0}}, thr_q[P_FIELD_W-1:0], {P_SHIFT{1'b0}}};
            assign resume_lvl = {{P_PAD{1'b0}}, thr_q[2*P_FIELD_W-1:P_FIELD_W], {P_SHIFT{1'b0}}};
        end else begin : g_nopad
            assign halt_lvl   = {thr_q[P_FIELD_W-1:0], {P_SHIFT{1'b0}}};
            assign resume_lvl = {thr_q[2*P_FIELD_W-1:P_FIELD_W], {P_SHIFT{1'b0}}};
        end
    endgenerate

    flowctl_rts_hyst #(.FILL_W(P_FILL_W)) u_rts (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .sw_rts(sw_rts),
        .fill(rx_fill), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
        .rts_n(rts_n), .chg_evt(rts_evt)
    );

    flowctl_cts_gate #(.SYNC_STAGES(P_SYNC)) u_cts (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .cts_n(cts_n),
        .tx_start_ok(tx_start_ok), .edge_evt(cts_evt)
    );

    // Sticky flags: a new event wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rts <= 1'b0;
            irq_cts <= 1'b0;
        end else begin
            irq_rts <= (irq_rts & ~stat_rd) | (rts_evt & rts_irq_en);
            irq_cts <= (irq_cts & ~stat_rd) | cts_evt;
        end
    end

    assign irq = irq_rts | irq_cts;
endmodule

// File: rtl/flowctl_checker.sv
// Temporal checks on the flow controller, attached with bind.
module flowctl_checker #(
    parameter int unsigned FILL_W = 7,
    parameter int unsigned THR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enh_en,
    input logic              auto_rts_en,
    input logic              auto_cts_en,
    input logic              sw_rts,
    input logic [FILL_W-1:0] rx_fill,
    input logic              cts_n,
    input logic              stat_rd,
    input logic [THR_W-1:0]  thr_q,
    input logic [FILL_W-1:0] halt_lvl,
    input logic [FILL_W-1:0] resume_lvl,
    input logic              rts_n,
    input logic              tx_start_ok,
    input logic              irq_rts,
    input logic              irq_cts
);
    a_r2_wr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |=> $stable(thr_q));

    a_r3_sw_rts: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> (rts_n == !$past(sw_rts)));

    a_r4_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_fill >= halt_lvl) |=> rts_n);

    a_r5_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_fill < halt_lvl && rx_fill <= resume_lvl) |=> !rts_n);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && $past(auto_rts_en) && rx_fill < halt_lvl && rx_fill > resume_lvl)
        |=> $stable(rts_n));

    a_r8_cts_free: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |-> tx_start_ok);

    a_r9_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && $past(cts_n, 2)) |-> !tx_start_ok);

    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !auto_rts_en && !auto_cts_en) |=> (!irq_rts && !irq_cts));
endmodule

bind flowctl_top flowctl_checker #(.FILL_W(P_FILL_W), .THR_W(2*P_FIELD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .auto_rts_en(auto_rts_en),
    .auto_cts_en(auto_cts_en), .sw_rts(sw_rts), .rx_fill(rx_fill), .cts_n(cts_n),
    .stat_rd(stat_rd), .thr_q(thr_q), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
    .rts_n(rts_n), .tx_start_ok(tx_start_ok), .irq_rts(irq_rts), .irq_cts(irq_cts)
);

// File: tb/sim_flowctl_top.sv
module sim_flowctl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       enh_en = 1'b0;
    logic       auto_rts_en = 1'b0;
    logic       auto_cts_en = 1'b0;
    logic       sw_rts = 1'b0;
    logic       rts_irq_en = 1'b0;
    logic [6:0] rx_fill = '0;
    logic       cts_n = 1'b1;
    logic       stat_rd = 1'b0;
    logic [7:0] thr_q;
    logic       rts_n, tx_start_ok, irq_rts, irq_cts, irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flowctl_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .enh_en(enh_en), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .sw_rts(sw_rts), .rts_irq_en(rts_irq_en), .rx_fill(rx_fill), .cts_n(cts_n),
        .stat_rd(stat_rd), .thr_q(thr_q), .rts_n(rts_n), .tx_start_ok(tx_start_ok),
        .irq_rts(irq_rts), .irq_cts(irq_cts), .irq(irq)
    );

    // Hysteresis walk with halt = 32 and resume = 16: {fill, expected rts_n}.
    localparam logic [7:0] VEC [0:12] = '{
        {7'd0, 1'b0}, {7'd20, 1'b0}, {7'd31, 1'b0}, {7'd32, 1'b1}, {7'd40, 1'b1},
        {7'd20, 1'b1}, {7'd17, 1'b1}, {7'd16, 1'b0}, {7'd10, 1'b0}, {7'd31, 1'b0},
        {7'd63, 1'b1}, {7'd64, 1'b1}, {7'd16, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply at the falling edge, let one rising edge pass, sample 1 ns later.
    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic write_thr(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 thr", thr_q, 8'h0F);
        check("R1 rts_n", {7'd0, rts_n}, 8'd1);
        check("R1 tx_start_ok", {7'd0, tx_start_ok}, 8'd1);
        check("R1 irq", {5'd0, irq_rts, irq_cts, irq}, 8'd0);

        // R2 write dropped without enh_en, accepted with it
        write_thr(8'hAA);
        check("R2 gated write", thr_q, 8'h0F);
        enh_en = 1'b1;
        write_thr(8'h48);
        check("R2 enabled write", thr_q, 8'h48);

        // R3 software RTS while auto off
        @(negedge clk); sw_rts = 1'b1; step();
        check("R3 sw assert", {7'd0, rts_n}, 8'd0);
        @(negedge clk); sw_rts = 1'b0; step();
        check("R3 sw release", {7'd0, rts_n}, 8'd1);

        // R4 R5 R6 hysteresis table
        @(negedge clk); auto_rts_en = 1'b1; sw_rts = 1'b1;
        for (int i = 0; i < 13; i++) begin
            if (i != 0) @(negedge clk);
            rx_fill = VEC[i][7:1];
            step();
            check($sformatf("R4/R5/R6 fill %0d", VEC[i][7:1]), {7'd0, rts_n}, {7'd0, VEC[i][0]});
        end
        check("R10 no flag while disabled", {7'd0, irq_rts}, 8'd0);

        // R7 overlap: halt 8, resume 20
        write_thr(8'h52);
        @(negedge clk); rx_fill = 7'd10; step();
        check("R7 halt wins", {7'd0, rts_n}, 8'd1);
        @(negedge clk); rx_fill = 7'd5; step();
        check("R7 below both", {7'd0, rts_n}, 8'd0);

        // R10 flag set on RTS change with enable
        @(negedge clk); rts_irq_en = 1'b1; rx_fill = 7'd9; step();
        check("R10 rts flag", {6'd0, irq_rts, irq}, 8'd3);
        // R12 clear on status read
        @(negedge clk); stat_rd = 1'b1; step();
        stat_rd = 1'b0;
        check("R12 rts clear", {6'd0, irq_rts, irq}, 8'd0);

        // R8 CTS ignored while auto-CTS off
        @(negedge clk); cts_n = 1'b1; step(); step(); step();
        check("R8 free tx", {6'd0, tx_start_ok, irq_cts}, 8'd2);

        // R9 R11 gate and flag timing under auto-CTS
        @(negedge clk); cts_n = 1'b0; step(); step(); step();
        @(negedge clk); auto_cts_en = 1'b1; #1;
        check("R9 clear to send", {7'd0, tx_start_ok}, 8'd1);
        @(negedge clk); cts_n = 1'b1; step();
        check("R9 one stage only", {7'd0, tx_start_ok}, 8'd1);
        step();
        check("R9 gated", {6'd0, tx_start_ok, irq_cts}, 8'd0);
        step();
        check("R11 cts flag", {6'd0, irq_cts, irq}, 8'd3);
        @(negedge clk); stat_rd = 1'b1; step();
        stat_rd = 1'b0;
        check("R12 cts clear", {7'd0, irq_cts}, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule